// File: doc/BRIEF.md
# Multi-core global timer with per-core comparators

The block keeps one 64-bit up-counter that all cores share. A prescaler slows it down: the counter advances once every (prescale + 1) clock cycles. Each core owns a 64-bit comparator, an auto-increment step, a sticky status flag, enable bits and an interrupt line. When the timer runs and a core's comparator is enabled, that core's status is set as soon as the count is at or above its comparator. With auto-increment, the comparator then moves past the count by whole steps, which gives periodic events.

Software reaches the registers through a 32-bit word interface. Each core has a 0x20-byte window, picked by `bus_win`. An alias path (`bus_alias` = 1) routes the access to the window of the core named by the requester ID `bus_cid`. Writes take effect at the rising clock edge. Read data is combinational while a read is presented.

Top module: `mc_gtimer`

## Requirements
- R1: While timer enable (control bit 0) is set, the counter rises by one every (P + 1) clock edges, where P is control bits 15:8. The prescale phase restarts whenever the timer is stopped. While the timer is stopped, the counter holds.
- R2: The counter words (low at offset 0x00, high at 0x04) are shared by all windows. They can be loaded only while the timer is stopped. Writes to them while the timer runs are ignored.
- R3: For a core, a compare hit happens when timer enable, that core's comparator enable (control bit 1) and count >= comparator are all true. A hit sets the core's status (bit 0 at offset 0x0C) at the next edge.
- R4: On a hit, the comparator moves to comparator + k*step if auto-increment (control bit 3) is set and the step (offset 0x18) is nonzero. Here k is the smallest whole number that puts the result above the count. With auto-increment off, the comparator stays unchanged. The comparator is read at offsets 0x10 (low) and 0x14 (high).
- R5: Each core's interrupt output equals its status flag ANDed with its interrupt enable (control bit 2).
- R6: Status is sticky. Writing 1 in bit 0 of 0x0C clears it and writing 0 has no effect. A hit in the same cycle as a clear wins over the clear.
- R7: Timer enable and prescale are shared by all cores. Comparator enable, interrupt enable and auto-increment are banked per core. A control read (0x08) returns the shared bits together with the bits of the accessed core.
- R8: Reads of offsets 0x1C, of addresses whose two low bits are nonzero, or of a core index at or beyond the core count return zero. Writes to any of these change nothing.
- R9: With `bus_alias` set, an access is routed to the core given by `bus_cid` instead of `bus_win`.
- R10: Reset clears the counter, the prescale phase, the shared control bits and every core's comparator, step, status and banked control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_alias | input | 1 | Route access by requester ID |
| bus_win | input | CID_W | Core window index for direct accesses |
| bus_cid | input | CID_W | ID of the requesting core |
| bus_addr | input | 5 | Byte offset inside the 0x20-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is presented |
| irq | output | NCORE | Per-core interrupt outputs |

## Verification
The hardest case to reach is an auto-increment re-arm that must skip several steps at once. It needs the count to be far past the comparator at the moment the timer starts. The stimulus stops the timer, loads a large count, places the comparator well below it with a step of ten, and then starts the timer. One edge later the comparator must hold the smallest value above the count. A single-step re-arm after a normal crossing is also checked, as is a hit that occurs exactly when the count equals the comparator.

// File: rtl/mgt_pkg.sv
package mgt_pkg;
  localparam int CNT_W = 64;
  localparam int DW    = 32;
  localparam int INC_W = 32;
  localparam int PS_W  = 8;

  // word index = byte offset / 4
  localparam logic [2:0] IDX_CNT_LO = 3'd0;
  localparam logic [2:0] IDX_CNT_HI = 3'd1;
  localparam logic [2:0] IDX_CTL    = 3'd2;
  localparam logic [2:0] IDX_STAT   = 3'd3;
  localparam logic [2:0] IDX_CMP_LO = 3'd4;
  localparam logic [2:0] IDX_CMP_HI = 3'd5;
  localparam logic [2:0] IDX_STEP   = 3'd6;

  localparam int B_RUN  = 0;
  localparam int B_CE   = 1;
  localparam int B_IE   = 2;
  localparam int B_AUTO = 3;
  localparam int B_PS   = 8;

  // Smallest cmp + k*step strictly above cnt (caller ensures cnt >= cmp).
  function automatic logic [CNT_W-1:0] next_cmp(input logic [CNT_W-1:0] cmp,
                                                input logic [CNT_W-1:0] cnt,
                                                input logic [INC_W-1:0] step);
    logic [CNT_W-1:0] step_w;
    logic [CNT_W-1:0] k;
    step_w = {{(CNT_W-INC_W){1'b0}}, step};
    if (step == '0) return cmp;
    k = (cnt - cmp) / step_w + 1'b1;
    return cmp + k * step_w;
  endfunction
endpackage

// File: rtl/mgt_counter.sv
module mgt_counter
  import mgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PS_W-1:0]  presc,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [DW-1:0]    wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  logic [PS_W-1:0] phase;

  assign tick = run && (phase == presc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      cnt   <= '0;
    end else if (!run) begin
      phase <= '0;
      if (ld_lo) cnt[DW-1:0]     <= wdata;
      if (ld_hi) cnt[CNT_W-1:DW] <= wdata;
    end else if (tick) begin
      phase <= '0;
      cnt   <= cnt + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/mgt_core_cmp.sv
module mgt_core_cmp
  import mgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ctl_wr,
  input  logic [2:0]       ctl_bits,   // {auto, ie, ce}
  input  logic             stat_clr,
  input  logic             cmp_lo_wr,
  input  logic             cmp_hi_wr,
  input  logic             step_wr,
  input  logic [DW-1:0]    wdata,
  output logic             ce,
  output logic             ie,
  output logic             au,
  output logic [CNT_W-1:0] cmp,
  output logic [INC_W-1:0] step,
  output logic             stat,
  output logic             hit,
  output logic             irq
);
  logic rearm;

  assign hit   = run && ce && (cnt >= cmp);
  assign rearm = hit && au && (step != '0);
  assign irq   = stat && ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce   <= 1'b0;
      ie   <= 1'b0;
      au   <= 1'b0;
      cmp  <= '0;
      step <= '0;
      stat <= 1'b0;
    end else begin
      if (ctl_wr) {au, ie, ce} <= ctl_bits;
      if (step_wr) step <= wdata;
      if (cmp_lo_wr || cmp_hi_wr) begin
        if (cmp_lo_wr) cmp[DW-1:0]     <= wdata;
        if (cmp_hi_wr) cmp[CNT_W-1:DW] <= wdata;
      end else if (rearm) begin
        cmp <= next_cmp(cmp, cnt, step);
      end
      if (hit)           stat <= 1'b1;
      else if (stat_clr) stat <= 1'b0;
    end
  end
endmodule

// File: rtl/mc_gtimer.sv
module mc_gtimer
  import mgt_pkg::*;
#(
  parameter int NCORE = 2,
  parameter int CID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic             bus_alias,
  input  logic [CID_W-1:0] bus_win,
  input  logic [CID_W-1:0] bus_cid,
  input  logic [4:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [NCORE-1:0] irq
);
  logic [CID_W-1:0] tgt;
  logic             core_ok, aligned, wr_ok, rd_ok;
  logic [2:0]       widx;

  logic             run_q;
  logic [PS_W-1:0]  presc_q;
  logic [CNT_W-1:0] cnt;
  logic             cnt_tick;
  logic             ld_lo, ld_hi, ctl_wr;

  logic [NCORE-1:0]            c_ce, c_ie, c_au, c_stat, c_hit, stat_clr, cmp_wr;
  logic [NCORE-1:0][CNT_W-1:0] c_cmp;
  logic [NCORE-1:0][INC_W-1:0] c_step;

  assign tgt     = bus_alias ? bus_cid : bus_win;
  assign core_ok = (int'(tgt) < NCORE);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[4:2];
  assign wr_ok   = bus_en && bus_wr && aligned && core_ok;
  assign rd_ok   = bus_en && !bus_wr && aligned && core_ok;
  assign ld_lo   = wr_ok && (widx == IDX_CNT_LO);
  assign ld_hi   = wr_ok && (widx == IDX_CNT_HI);
  assign ctl_wr  = wr_ok && (widx == IDX_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      presc_q <= '0;
    end else if (ctl_wr) begin
      run_q   <= bus_wdata[B_RUN];
      presc_q <= bus_wdata[B_PS +: PS_W];
    end
  end

  mgt_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .presc (presc_q),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .wdata (bus_wdata),
    .cnt   (cnt),
    .tick  (cnt_tick)
  );

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic sel;
    assign sel         = wr_ok && (tgt == CID_W'(i));
    assign stat_clr[i] = sel && (widx == IDX_STAT) && bus_wdata[0];
    assign cmp_wr[i]   = sel && ((widx == IDX_CMP_LO) || (widx == IDX_CMP_HI));

    mgt_core_cmp u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .cnt       (cnt),
      .ctl_wr    (sel && (widx == IDX_CTL)),
      .ctl_bits  ({bus_wdata[B_AUTO], bus_wdata[B_IE], bus_wdata[B_CE]}),
      .stat_clr  (stat_clr[i]),
      .cmp_lo_wr (sel && (widx == IDX_CMP_LO)),
      .cmp_hi_wr (sel && (widx == IDX_CMP_HI)),
      .step_wr   (sel && (widx == IDX_STEP)),
      .wdata     (bus_wdata),
      .ce        (c_ce[i]),
      .ie        (c_ie[i]),
      .au        (c_au[i]),
      .cmp       (c_cmp[i]),
      .step      (c_step[i]),
      .stat      (c_stat[i]),
      .hit       (c_hit[i]),
      .irq       (irq[i])
    );
  end

  always_comb begin
    logic             s_ce, s_ie, s_au, s_stat;
    logic [CNT_W-1:0] s_cmp;
    logic [INC_W-1:0] s_step;
    s_ce = 1'b0; s_ie = 1'b0; s_au = 1'b0; s_stat = 1'b0;
    s_cmp = '0; s_step = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (tgt == CID_W'(i)) begin
        s_ce = c_ce[i]; s_ie = c_ie[i]; s_au = c_au[i]; s_stat = c_stat[i];
        s_cmp = c_cmp[i]; s_step = c_step[i];
      end
    end
    bus_rdata = '0;
    if (rd_ok) begin
      case (widx)
        IDX_CNT_LO: bus_rdata = cnt[DW-1:0];
        IDX_CNT_HI: bus_rdata = cnt[CNT_W-1:DW];
        IDX_CTL: begin
          bus_rdata[B_RUN]          = run_q;
          bus_rdata[B_CE]           = s_ce;
          bus_rdata[B_IE]           = s_ie;
          bus_rdata[B_AUTO]         = s_au;
          bus_rdata[B_PS +: PS_W]   = presc_q;
        end
        IDX_STAT:   bus_rdata[0] = s_stat;
        IDX_CMP_LO: bus_rdata = s_cmp[DW-1:0];
        IDX_CMP_HI: bus_rdata = s_cmp[CNT_W-1:DW];
        IDX_STEP:   bus_rdata = s_step;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mgt_checker.sv
module mgt_checker
  import mgt_pkg::*;
#(
  parameter int NCORE = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        run,
  input logic                        tick,
  input logic [CNT_W-1:0]            cnt,
  input logic [NCORE-1:0]            hit,
  input logic [NCORE-1:0]            stat,
  input logic [NCORE-1:0]            ie,
  input logic [NCORE-1:0]            au,
  input logic [NCORE-1:0]            clr,
  input logic [NCORE-1:0]            cmp_wr,
  input logic [NCORE-1:0][CNT_W-1:0] cmp,
  input logic [NCORE-1:0][INC_W-1:0] step,
  input logic [NCORE-1:0]            irq
);
  a_r1_tick_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 64'd1);

  a_r2_running_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  for (genvar i = 0; i < NCORE; i++) begin : g_chk
    a_r3_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> stat[i]);

    a_r4_rearm_ahead: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && au[i] && (step[i] != '0) && !cmp_wr[i]) |=> cmp[i] > $past(cnt));

    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (stat[i] && ie[i]));

    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[i] && !clr[i]) |=> stat[i]);
  end
endmodule

bind mc_gtimer mgt_checker #(.NCORE(NCORE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (run_q),
  .tick   (cnt_tick),
  .cnt    (cnt),
  .hit    (c_hit),
  .stat   (c_stat),
  .ie     (c_ie),
  .au     (c_au),
  .clr    (stat_clr),
  .cmp_wr (cmp_wr),
  .cmp    (c_cmp),
  .step   (c_step),
  .irq    (irq)
);

// File: tb/mc_gtimer_tb.sv
module mc_gtimer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0, bus_alias = 1'b0;
  logic [1:0]  bus_win = '0, bus_cid = '0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_gtimer #(.NCORE(NC), .CID_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_alias(bus_alias), .bus_win(bus_win), .bus_cid(bus_cid),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic        al;
    logic [1:0]  win;
    logic [1:0]  cid;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 2'd0, 2'd0, 5'h10, 32'h1111_1111, 32'h0, 4'd8},  // R8
    '{1'b1, 1'b0, 2'd1, 2'd0, 5'h10, 32'h2222_2222, 32'h0, 4'd8},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h10, 32'h0, 32'h1111_1111, 4'd8},
    '{1'b0, 1'b1, 2'd0, 2'd1, 5'h10, 32'h0, 32'h2222_2222, 4'd9},  // R9
    '{1'b1, 1'b1, 2'd1, 2'd0, 5'h18, 32'h5, 32'h0, 4'd9},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h18, 32'h0, 32'h5, 4'd9},
    '{1'b1, 1'b0, 2'd0, 2'd0, 5'h08, 32'h306, 32'h0, 4'd7},        // R7
    '{1'b0, 1'b0, 2'd1, 2'd0, 5'h08, 32'h0, 32'h300, 4'd7},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h08, 32'h0, 32'h306, 4'd7},
    '{1'b1, 1'b0, 2'd1, 2'd0, 5'h00, 32'hABCD, 32'h0, 4'd2},       // R2
    '{1'b1, 1'b0, 2'd1, 2'd0, 5'h04, 32'h1, 32'h0, 4'd2},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h00, 32'h0, 32'hABCD, 4'd2},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h04, 32'h0, 32'h1, 4'd2},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h1C, 32'h0, 32'h0, 4'd8},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h11, 32'h0, 32'h0, 4'd8},
    '{1'b1, 1'b0, 2'd0, 2'd0, 5'h12, 32'hFFFF_FFFF, 32'h0, 4'd8},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h10, 32'h0, 32'h1111_1111, 4'd8},
    '{1'b0, 1'b0, 2'd2, 2'd0, 5'h10, 32'h0, 32'h0, 4'd8},
    '{1'b1, 1'b0, 2'd3, 2'd0, 5'h08, 32'h1, 32'h0, 4'd8},
    '{1'b0, 1'b0, 2'd0, 2'd0, 5'h08, 32'h0, 32'h306, 4'd8}
  };

  // All tasks start and end at a falling edge; wr spans exactly one rising edge.
  task automatic wr(input logic al, input logic [1:0] w, input logic [1:0] c,
                    input logic [4:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_alias = al; bus_win = w; bus_cid = c;
    bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_alias = 1'b0;
  endtask

  task automatic rd(input logic al, input logic [1:0] w, input logic [1:0] c,
                    input logic [4:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_alias = al; bus_win = w; bus_cid = c;
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0; bus_alias = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rchk(input string tag, input logic [1:0] w, input logic [4:0] a,
                      input logic [31:0] exp);
    logic [31:0] d;
    rd(1'b0, w, 2'd0, a, d);
    check(tag, d, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    check("R10 irq after reset", {30'd0, irq}, 32'h0);
    rchk("R10 count after reset", 2'd0, 5'h00, 32'h0);

    // register file table
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) begin
        wr(TBL[i].al, TBL[i].win, TBL[i].cid, TBL[i].addr, TBL[i].data);
      end else begin
        rd(TBL[i].al, TBL[i].win, TBL[i].cid, TBL[i].addr, d);
        checks++;
        if (d !== TBL[i].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", TBL[i].req, i, d, TBL[i].exp);
        end
      end
    end

    // R10: reset clears everything written above
    do_reset();
    rchk("R10 count hi", 2'd0, 5'h04, 32'h0);
    rchk("R10 control", 2'd0, 5'h08, 32'h0);
    rchk("R10 cmp core1", 2'd1, 5'h10, 32'h0);
    rchk("R10 step core0", 2'd0, 5'h18, 32'h0);

    // R1: prescale 2 -> one step every 3 edges
    wr(1'b0, 2'd0, 2'd0, 5'h08, 32'h0201);
    repeat (9) @(negedge clk);
    rchk("R1 count after 9 edges", 2'd0, 5'h00, 32'd3);
    repeat (2) @(negedge clk);
    rchk("R1 count after 11 edges", 2'd0, 5'h00, 32'd3);
    repeat (1) @(negedge clk);
    rchk("R1 count after 12 edges", 2'd0, 5'h00, 32'd4);
    wr(1'b0, 2'd0, 2'd0, 5'h00, 32'h0);
    rchk("R2 load ignored while running", 2'd0, 5'h00, 32'd4);
    wr(1'b0, 2'd0, 2'd0, 5'h08, 32'h0);
    repeat (5) @(negedge clk);
    rchk("R1 count holds when stopped", 2'd0, 5'h00, 32'd4);

    // R3/R5/R6: core1 compare at 10, prescale 0
    wr(1'b0, 2'd1, 2'd0, 5'h00, 32'h0);
    wr(1'b0, 2'd1, 2'd0, 5'h10, 32'd10);
    wr(1'b0, 2'd1, 2'd0, 5'h08, 32'h07);
    repeat (10) @(negedge clk);
    rchk("R3 no status before equal", 2'd1, 5'h0C, 32'h0);
    check("R5 irq low before hit", {30'd0, irq}, 32'h0);
    repeat (1) @(negedge clk);
    rchk("R3 status on equal", 2'd1, 5'h0C, 32'h1);
    check("R5 irq core1 only", {30'd0, irq}, 32'h2);
    rchk("R4 cmp unchanged without auto", 2'd1, 5'h10, 32'd10);
    wr(1'b0, 2'd1, 2'd0, 5'h08, 32'h06);
    repeat (3) @(negedge clk);
    rchk("R6 status sticky when stopped", 2'd1, 5'h0C, 32'h1);
    wr(1'b0, 2'd1, 2'd0, 5'h08, 32'h02);
    check("R5 irq masked by enable", {30'd0, irq}, 32'h0);
    wr(1'b0, 2'd1, 2'd0, 5'h08, 32'h06);
    check("R5 irq unmasked", {30'd0, irq}, 32'h2);
    wr(1'b0, 2'd1, 2'd0, 5'h0C, 32'h0);
    rchk("R6 write zero keeps status", 2'd1, 5'h0C, 32'h1);
    wr(1'b0, 2'd1, 2'd0, 5'h0C, 32'h1);
    rchk("R6 write one clears", 2'd1, 5'h0C, 32'h0);
    check("R6 irq low after clear", {30'd0, irq}, 32'h0);

    // R4: auto-increment single steps, core0
    wr(1'b0, 2'd0, 2'd0, 5'h00, 32'h0);
    wr(1'b0, 2'd0, 2'd0, 5'h10, 32'd5);
    wr(1'b0, 2'd0, 2'd0, 5'h18, 32'd4);
    wr(1'b0, 2'd0, 2'd0, 5'h08, 32'h0B);
    repeat (7) @(negedge clk);
    rchk("R4 first re-arm", 2'd0, 5'h10, 32'd9);
    repeat (4) @(negedge clk);
    rchk("R4 second re-arm", 2'd0, 5'h10, 32'd13);

    // R4: multi-step catch-up
    wr(1'b0, 2'd0, 2'd0, 5'h08, 32'h0A);
    wr(1'b0, 2'd0, 2'd0, 5'h00, 32'd100);
    wr(1'b0, 2'd0, 2'd0, 5'h10, 32'd7);
    wr(1'b0, 2'd0, 2'd0, 5'h18, 32'd10);
    wr(1'b0, 2'd0, 2'd0, 5'h08, 32'h0B);
    repeat (1) @(negedge clk);
    rchk("R4 catch-up comparator", 2'd0, 5'h10, 32'd107);
    rchk("R1 count one edge after start", 2'd0, 5'h00, 32'd101);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule